// File: doc/BRIEF.md
# Fractional Core Clock Pulse Swallower

This block derives a core clock from a parent clock by letting through N of every 32 parent pulses and suppressing the rest. The average output rate is therefore parent × N / 32, with N anywhere from 1 to 32. The pulses that pass are spread as evenly as possible across each 32-cycle window by an accumulator. The output is gated by a latch that is transparent only while the parent clock is low, so the output never carries a runt pulse.

Software sets the rate through a small register port. It writes a 5-bit rate code into a frequency register, where the code holds 32 − N. It then sets a request bit in a control register. The request bit stays set while the change is pending, and software polls it. The sequencer waits for the current 32-cycle window to end and loads the new multiplier exactly at the boundary. After one more settle cycle it clears the request bit. While a change is pending, the frequency register refuses all writes and a second request has no effect.

Sequencer states are `SEQ_IDLE`, `SEQ_ARMED` and `SEQ_SETTLE`. The transitions are:
- IDLE→ARMED on an accepted request.
- ARMED→SETTLE on the last cycle of a window. The multiplier load happens on this transition.
- SETTLE→IDLE unconditionally. The request bit clears on this transition.

Top module: `core_clk_swallower`

## Requirements
- R1: After reset the rate code reads 0, the request bit reads 0, and the output passes every parent pulse (64 of any 64 cycles).
- R2: With multiplier N, any 32 consecutive output slots contain exactly N pulses, for every N from 1 to 32.
- R3: The rate code is bits 12:8 of the frequency register at offset 0x0E0 and encodes 32 − N (code 0 gives N = 32, code 31 gives N = 1).
- R4: The bits of the frequency register outside the rate code read back as written. All other bits of the control register read 0. Any unmapped offset reads 0.
- R5: Writing the rate code without a request leaves the output rate unchanged, although the register reads back the new code.
- R6: The request bit is bit 31 of the control register at offset 0x004. Writing 1 to it while idle sets it, and it reads 1 while the change is pending. Writing 0 never clears it.
- R7: A requested multiplier is loaded only at a 32-cycle window boundary, and the request bit reads 0 again within 40 cycles of the request.
- R8: While the request bit is set, writes to the frequency register are ignored.
- R9: The gap between consecutive output pulses never exceeds ceil(32/N) parent cycles.
- R10: The output is low whenever the parent clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_clk | output | 1 | Pulse-swallowed core clock |

## Verification
The assertions assume the register port is driven synchronously to the parent clock and that the write strobe, offset and data are stable around each rising edge. The bench meets this by changing them only on falling edges. The assertions also assume that software changes the multiplier only through the request bit. The bench therefore does every rate change through a code write followed by a request and a poll. It deliberately issues writes while a request is pending, because those writes are meant to be refused.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ARMED  = 2'd1,
        SEQ_SETTLE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/fcs_regs.sv
module fcs_regs #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int FIELD_W   = 5,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter logic [ADDR_W-1:0] FREQ_OFS = 12'h0E0,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic [FIELD_W-1:0] field,
    output logic              kick_req
);
    logic [DATA_W-1:0] freq_q;
    logic hit_freq, hit_ctrl;

    assign hit_freq = (addr == FREQ_OFS);
    assign hit_ctrl = (addr == CTRL_OFS);

    // frequency register is frozen while a change is in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            freq_q <= '0;
        else if (wr && hit_freq && !busy)
            freq_q <= wdata;
    end

    assign field    = freq_q[FIELD_LSB +: FIELD_W];
    assign kick_req = wr && hit_ctrl && wdata[KICK_BIT] && !busy;

    always_comb begin
        rdata = '0;
        if (hit_freq)
            rdata = freq_q;
        else if (hit_ctrl)
            rdata[KICK_BIT] = busy;
    end
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
    import fcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_req,
    input  logic win_last,
    output logic busy,
    output logic load
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (kick_req) state_d = SEQ_ARMED;
            SEQ_ARMED:  if (win_last) state_d = SEQ_SETTLE;
            SEQ_SETTLE: state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        busy = 1'b0;
        load = 1'b0;
        unique case (state_q)
            SEQ_IDLE:   ;
            SEQ_ARMED: begin
                busy = 1'b1;
                load = win_last;
            end
            SEQ_SETTLE: busy = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/fcs_pattern.sv
module fcs_pattern #(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] field,
    output logic [FIELD_W-1:0] phase,
    output logic [FIELD_W:0]   active_mult,
    output logic               pulse,
    output logic               win_last,
    output logic               en_q
);
    localparam int MW     = FIELD_W + 1;
    localparam int WINDOW = 1 << FIELD_W;

    logic [FIELD_W:0] acc_q, acc_d;
    logic [MW:0]      sum;

    assign win_last = (phase == FIELD_W'(WINDOW - 1));
    assign sum      = {1'b0, acc_q} + {1'b0, active_mult};
    assign pulse    = (sum >= (MW+1)'(WINDOW));
    assign acc_d    = pulse ? MW'(sum - (MW+1)'(WINDOW)) : MW'(sum);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase       <= '0;
            acc_q       <= '0;
            active_mult <= MW'(WINDOW);
            en_q        <= 1'b0;
        end else begin
            phase <= phase + 1'b1;
            en_q  <= pulse;
            acc_q <= win_last ? '0 : acc_d;
            if (load)
                active_mult <= MW'(WINDOW) - {1'b0, field};
        end
    end
endmodule

// File: rtl/fcs_clkgate.sv
module fcs_clkgate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_lat;

    always_latch begin
        if (!clk_in)
            en_lat = en;
    end

    assign clk_out = clk_in & en_lat;
endmodule

// File: rtl/core_clk_swallower.sv
module core_clk_swallower #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int FIELD_W   = 5,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter logic [ADDR_W-1:0] FREQ_OFS = 12'h0E0,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              core_clk
);
    logic [FIELD_W-1:0] field;
    logic [FIELD_W-1:0] phase;
    logic [FIELD_W:0]   active_mult;
    logic kick_req, busy, load, win_last, pulse, en_q;

    fcs_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
        .FIELD_LSB(FIELD_LSB), .KICK_BIT(KICK_BIT),
        .FREQ_OFS(FREQ_OFS), .CTRL_OFS(CTRL_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .busy(busy), .rdata(bus_rdata),
        .field(field), .kick_req(kick_req)
    );

    fcs_seq u_seq (
        .clk(clk), .rst_n(rst_n), .kick_req(kick_req),
        .win_last(win_last), .busy(busy), .load(load)
    );

    fcs_pattern #(.FIELD_W(FIELD_W)) u_pattern (
        .clk(clk), .rst_n(rst_n), .load(load), .field(field),
        .phase(phase), .active_mult(active_mult), .pulse(pulse),
        .win_last(win_last), .en_q(en_q)
    );

    fcs_clkgate u_gate (
        .clk_in(clk), .en(en_q), .clk_out(core_clk)
    );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12,
    parameter int FIELD_W  = 5,
    parameter int KICK_BIT = 31,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h004
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               busy,
    input logic [FIELD_W-1:0] field,
    input logic [FIELD_W-1:0] phase,
    input logic [FIELD_W:0]   active_mult,
    input logic               pulse
);
    localparam int WINDOW = 1 << FIELD_W;

    logic [FIELD_W:0] win_cnt;
    logic [FIELD_W:0] win_total;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (phase == FIELD_W'(WINDOW - 1))
            win_cnt <= '0;
        else
            win_cnt <= win_cnt + {{FIELD_W{1'b0}}, pulse};
    end

    assign win_total = win_cnt + {{FIELD_W{1'b0}}, pulse};

    assert_window_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == FIELD_W'(WINDOW - 1)) |-> (win_total == active_mult));

    assert_load_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_mult) |-> (phase == '0));

    assert_done_matches_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (active_mult == (FIELD_W+1)'(WINDOW) - {1'b0, field}));

    assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(field));

    assert_kick_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && (bus_addr == CTRL_OFS) && bus_wdata[KICK_BIT]));
endmodule

bind core_clk_swallower fcs_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
    .KICK_BIT(KICK_BIT), .CTRL_OFS(CTRL_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .field(field), .phase(phase),
    .active_mult(active_mult), .pulse(pulse)
);

// File: tb/core_clk_swallower_bench.sv
`timescale 1ns/1ps
module core_clk_swallower_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam logic [11:0] FREQ = 12'h0E0;
    localparam logic [11:0] CTRL = 12'h004;

    always #5 clk = ~clk;

    core_clk_swallower u_core_clk_swallower (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_clk(core_clk)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic poll(output int n);
        logic [31:0] d;
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            rd(CTRL, d);
            n++;
            if (!d[31]) break;
        end
    endtask

    // counts output pulses over 64 cycles; reports the largest gap and low-phase glitches
    task automatic measure(output int cnt, output int maxgap, output int lowhits);
        int last;
        cnt = 0; maxgap = 0; lowhits = 0; last = -1;
        for (int i = 0; i < 64; i++) begin
            @(posedge clk); #2;
            if (core_clk) begin
                if (last >= 0 && (i - last) > maxgap) maxgap = i - last;
                last = i; cnt++;
            end
            @(negedge clk); #2;
            if (core_clk) lowhits++;
        end
    endtask

    task automatic settle();
        for (int i = 0; i < 40; i++) @(posedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int cnt, gap, low, n;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        settle();

        // R1: reset state
        rd(FREQ, d); check(d == 0, "R1 code", d, 0);
        rd(CTRL, d); check(d == 0, "R1 kick", d, 0);
        measure(cnt, gap, low);
        check(cnt == 64, "R1 full rate", cnt, 64);
        check(low == 0, "R10 low phase", low, 0);

        // R4: readback of other bits and unmapped offsets
        wr(FREQ, 32'hA5A5_005A);
        rd(FREQ, d); check(d == 32'hA5A5_005A, "R4 freq readback", d, 32'hA5A5_005A);
        rd(12'h010, d); check(d == 0, "R4 unmapped", d, 0);
        wr(CTRL, 32'h0000_00FF);
        rd(CTRL, d); check(d == 0, "R4 ctrl other bits", d, 0);

        // R5: code written without request has no effect (code 0x1B -> N=5)
        wr(FREQ, 32'h0000_1B00);
        rd(FREQ, d); check(d[12:8] == 5'd27, "R5 code readback", d[12:8], 27);
        measure(cnt, gap, low);
        check(cnt == 64, "R5 rate unchanged", cnt, 64);

        // R6/R7: request applies N=5
        wr(CTRL, 32'h8000_0000);
        rd(CTRL, d); check(d[31] == 1'b1, "R6 kick pending", d[31], 1);
        // R6: write 0 does not clear, R8: freq write refused (code 12 -> N=20)
        wr(CTRL, 32'h0);
        wr(FREQ, 32'h0000_0C00);
        rd(CTRL, d); check(d[31] == 1'b1, "R6 kick not cleared by 0", d[31], 1);
        poll(n);
        check(n <= 40, "R7 completion polls", n, 40);
        rd(FREQ, d); check(d[12:8] == 5'd27, "R8 write refused", d[12:8], 27);
        settle();
        measure(cnt, gap, low);
        check(cnt == 10, "R8 rate kept N=5", cnt, 10);

        // R2/R3/R9/R10/R7: sweep every multiplier
        for (int m = 1; m <= 32; m++) begin
            int code, ceilg;
            code = 32 - m;
            ceilg = (32 + m - 1) / m;
            wr(FREQ, 32'(code) << 8);
            wr(CTRL, 32'h8000_0000);
            poll(n);
            check(n <= 40, "R7 sweep completion", n, 40);
            settle();
            measure(cnt, gap, low);
            check(cnt == 2 * m, "R2 R3 pulses per 64", cnt, 2 * m);
            if (m < 32) check(gap <= ceilg, "R9 max gap", gap, ceilg);
            check(low == 0, "R10 glitch", low, 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule